// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time and a calendar date. It counts seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle `sec_tick` strobe, produced elsewhere once per second, advances it. The counter itself is held in binary. A visible register image presents it either as packed BCD (tens digit in bits 7:4) or as plain binary. Hours can be shown as 0-23, or as a 12-hour value with a PM flag in bit 7. A host writes individual time fields through a simple write strobe. A freeze control lets the host change several fields while the visible image stays still, and the counter takes the new time when the freeze is released.

Each accepted second starts an update sequence, run by a three-state machine.
- **IDLE** waits for a tick. The divider field must read 010; then the counter steps once and the machine moves to WINDOW.
- **WINDOW** holds the update-busy flag for `UIP_CYCLES` clock cycles and then moves to REFRESH.
- **REFRESH** lasts one cycle. It copies the counter into the image (unless frozen), compares the time against three alarm bytes, raises the status flags and clears the busy flag. It always returns to IDLE.

Ticks that arrive outside IDLE are dropped.

Top module: `bcd_calendar`

## Requirements
- R1: A tick advances the time only when `div_sel` equals 3'b010. Any other value leaves the time, the flags and `uip` untouched.
- R2: Seconds and minutes wrap from 59 to 0, and hours from 23 to 0. Day of week runs 1..7 and then back to 1. Month runs 1..12 and then back to 1. Year wraps from 99 to 0. Each rollover carries into the next field.
- R3: The last day of a month is 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February has 28 days, or 29 in a leap year. The leap test applies to `CENTURY_BASE` plus the two-digit year: the full year must be divisible by 4, and a full year divisible by 100 must also be divisible by 400.
- R4: With `bin_mode`=0 every field is held in packed BCD. With `bin_mode`=1 it is held in plain binary. Host-written bytes are read back in the same mode.
- R5: With `hr24_mode`=0 the hours byte holds hour mod 12 with bit 7 set for hours 12..23. So 13:00 reads 0x81 and noon reads 0x80. When a written hours byte is decoded, bit 7 is removed and adds 12 when set.
- R6: When `set_mode` is low, an accepted tick sets `uip` at the same edge. `uip` stays high for `UIP_CYCLES`+1 cycles. It falls at the edge where the image is refreshed. When `set_mode` is high, `uip` is forced low.
- R7: While `set_mode` is high, the image changes only through host writes, and those writes do not reach the counter. With `set_mode` low, a host write also loads the counter. When `set_mode` falls, the counter loads the whole image. Write field select: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Select 7 writes nothing.
- R8: An alarm byte whose bits 7:6 are both 1 matches any value. If all three alarm bytes match the time in the refresh cycle and `alarm_ie` is set, `alarm_flag` and `irq_flag` are both set.
- R9: Every refresh sets `update_flag`. It also sets `irq_flag` when `update_ie` is high. `flag_clr` clears all three flags, but a refresh in the same cycle wins.
- R10: If `bin_mode` or `hr24_mode` changes while `set_mode` is low, the whole image is rewritten from the counter in the new format at the next edge.
- R11: A host write that lands on the refresh edge keeps the written byte. The other fields take the refreshed values, and the counter loads this merged image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| div_sel | input | 3 | Divider field; counting runs only at 3'b010 |
| set_mode | input | 1 | Freeze visible image and busy flag |
| bin_mode | input | 1 | 1 = binary image, 0 = packed BCD |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_ie | input | 1 | Alarm match raises the request flag |
| update_ie | input | 1 | Update end raises the request flag |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data in the current format |
| flag_clr | input | 1 | Clear the three status flags |
| img_sec | output | 8 | Visible seconds |
| img_min | output | 8 | Visible minutes |
| img_hour | output | 8 | Visible hours |
| img_dow | output | 8 | Visible day of week |
| img_date | output | 8 | Visible day of month |
| img_month | output | 8 | Visible month |
| img_year | output | 8 | Visible two-digit year |
| uip | output | 1 | Update in progress |
| alarm_flag | output | 1 | Alarm matched |
| update_flag | output | 1 | Update ended |
| irq_flag | output | 1 | Interrupt request |

## Verification
The host write path and the REFRESH copy can fall in the same cycle, since both drive the visible image and the counter. The bench provokes this by issuing a minutes write exactly `UIP_CYCLES` cycles after the tick's edge, so that the write lands on the refresh edge. It judges the outcome by reading back the merged image. It then ticks once more to confirm that the counter carries the written minutes with the refreshed seconds. A behavioural model compares every output on every cycle, which also covers tick/freeze and flag-clear/refresh overlaps.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [NUM_FIELDS-1:0][6:0] cal_time_t;
    typedef logic [NUM_FIELDS-1:0][7:0] cal_img_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_REFRESH = 2'd2
    } cal_state_e;

    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return bin ? {1'b0, v} : {tens, ones};
    endfunction

    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : 7'(({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]});
    endfunction

    function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin,
                                            input logic h24);
        logic       pm;
        logic [6:0] h12;
        logic [7:0] e;
        pm  = (h >= 7'd12);
        h12 = pm ? h - 7'd12 : h;
        e   = enc_val(h12, bin);
        return h24 ? enc_val(h, bin) : {pm, e[6:0]};
    endfunction

    function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [6:0] h;
        h = dec_val({1'b0, b[6:0]}, bin);
        if (!h24 && b[7]) begin
            h = h + 7'd12;
        end
        return h;
    endfunction

    function automatic cal_time_t decode_img(input cal_img_t img, input logic bin,
                                             input logic h24);
        cal_time_t t;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            t[i] = (i == F_HOUR) ? dec_hour(img[i], bin, h24) : dec_val(img[i], bin);
        end
        return t;
    endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int CENTURY_BASE = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t now
);

    localparam cal_time_t RESET_TIME = {7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};

    int         full_year;
    logic       leap;
    logic [6:0] last_day;
    cal_time_t  stepped;

    always_comb begin
        full_year = CENTURY_BASE + int'(now[F_YEAR]);
        leap      = ((full_year % 4) == 0) &&
                    (((full_year % 100) != 0) || ((full_year % 400) == 0));
        case (now[F_MON])
            7'd2:                      last_day = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   last_day = 7'd30;
            default:                   last_day = 7'd31;
        endcase
    end

    always_comb begin
        stepped = now;
        if (now[F_SEC] < 7'd59) begin
            stepped[F_SEC] = now[F_SEC] + 7'd1;
        end else begin
            stepped[F_SEC] = 7'd0;
            if (now[F_MIN] < 7'd59) begin
                stepped[F_MIN] = now[F_MIN] + 7'd1;
            end else begin
                stepped[F_MIN] = 7'd0;
                if (now[F_HOUR] < 7'd23) begin
                    stepped[F_HOUR] = now[F_HOUR] + 7'd1;
                end else begin
                    stepped[F_HOUR] = 7'd0;
                    stepped[F_DOW]  = (now[F_DOW] >= 7'd7) ? 7'd1 : now[F_DOW] + 7'd1;
                    if (now[F_DATE] < last_day) begin
                        stepped[F_DATE] = now[F_DATE] + 7'd1;
                    end else begin
                        stepped[F_DATE] = 7'd1;
                        if (now[F_MON] < 7'd12) begin
                            stepped[F_MON] = now[F_MON] + 7'd1;
                        end else begin
                            stepped[F_MON]  = 7'd1;
                            stepped[F_YEAR] = (now[F_YEAR] >= 7'd99) ? 7'd0
                                                                      : now[F_YEAR] + 7'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= RESET_TIME;
        end else if (load) begin
            now <= load_val;
        end else if (adv) begin
            now <= stepped;
        end
    end

endmodule

// File: rtl/cal_format.sv
module cal_format
    import cal_pkg::*;
(
    input  cal_time_t now,
    input  logic      bin,
    input  logic      h24,
    output cal_img_t  img
);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        if (i == F_HOUR) begin : g_hour
            assign img[i] = enc_hour(now[i], bin, h24);
        end else begin : g_plain
            assign img[i] = enc_val(now[i], bin);
        end
    end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  cal_time_t       now,
    input  logic [2:0][7:0] alm,
    input  logic            bin,
    input  logic            h24,
    output logic            hit
);

    logic [2:0] field_ok;

    for (genvar i = 0; i < 3; i++) begin : g_cmp
        logic [6:0] want;
        if (i == F_HOUR) begin : g_hour
            assign want = dec_hour(alm[i], bin, h24);
        end else begin : g_plain
            assign want = dec_val(alm[i], bin);
        end
        assign field_ok[i] = (alm[i][7:6] == 2'b11) || (want == now[i]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int UIP_CYCLES   = 8,
    parameter int CENTURY_BASE = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [2:0] div_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       alarm_ie,
    input  logic       update_ie,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       flag_clr,
    output logic [7:0] img_sec,
    output logic [7:0] img_min,
    output logic [7:0] img_hour,
    output logic [7:0] img_dow,
    output logic [7:0] img_date,
    output logic [7:0] img_month,
    output logic [7:0] img_year,
    output logic       uip,
    output logic       alarm_flag,
    output logic       update_flag,
    output logic       irq_flag
);

    localparam int         CW        = $clog2(UIP_CYCLES + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(UIP_CYCLES - 1);
    localparam logic [2:0] DIV_RUN   = 3'b010;
    localparam cal_img_t   RESET_IMG = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    cal_state_e    state, state_nx;
    logic [CW-1:0] win_cnt;
    cal_time_t     core_now, core_ld_val;
    cal_img_t      image, fmt, base_img, img_next;
    logic          go, refresh, set_q, bin_q, h24_q;
    logic          release_set, core_ld, mode_chg, alm_hit, keep_img;

    assign go          = (state == ST_IDLE) && sec_tick && (div_sel == DIV_RUN);
    assign refresh     = (state == ST_REFRESH);
    assign release_set = set_q && !set_mode;
    assign core_ld     = (wr_en && !set_mode) || release_set;
    assign mode_chg    = ((bin_mode != bin_q) || (hr24_mode != h24_q)) && !set_mode;
    assign keep_img    = wr_en || (refresh && !set_mode);

    always_comb begin
        base_img = (refresh && !set_mode) ? fmt : image;
        img_next = base_img;
        if (wr_en && (wr_sel < 3'(NUM_FIELDS))) begin
            img_next[wr_sel] = wr_data;
        end
        core_ld_val = decode_img(img_next, bin_mode, hr24_mode);
    end

    cal_counter #(.CENTURY_BASE(CENTURY_BASE)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (go),
        .load     (core_ld),
        .load_val (core_ld_val),
        .now      (core_now)
    );

    cal_format u_format (
        .now (core_now),
        .bin (bin_mode),
        .h24 (hr24_mode),
        .img (fmt)
    );

    cal_alarm u_alarm (
        .now (core_now),
        .alm ({alm_hour, alm_min, alm_sec}),
        .bin (bin_mode),
        .h24 (hr24_mode),
        .hit (alm_hit)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go) state_nx = ST_WINDOW;
            ST_WINDOW:  if (win_cnt == WIN_LAST) state_nx = ST_REFRESH;
            ST_REFRESH: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            win_cnt <= '0;
        end else begin
            state   <= state_nx;
            win_cnt <= (state == ST_WINDOW && state_nx == ST_WINDOW) ? win_cnt + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            image       <= RESET_IMG;
            uip         <= 1'b0;
            alarm_flag  <= 1'b0;
            update_flag <= 1'b0;
            irq_flag    <= 1'b0;
            set_q       <= 1'b0;
            bin_q       <= 1'b0;
            h24_q       <= 1'b0;
        end else begin
            set_q <= set_mode;
            bin_q <= bin_mode;
            h24_q <= hr24_mode;

            if (keep_img) begin
                image <= img_next;
            end else if (mode_chg) begin
                image <= fmt;
            end

            if (refresh || set_mode) begin
                uip <= 1'b0;
            end else if (go) begin
                uip <= 1'b1;
            end

            if (flag_clr) begin
                alarm_flag  <= 1'b0;
                update_flag <= 1'b0;
                irq_flag    <= 1'b0;
            end
            if (refresh) begin
                update_flag <= 1'b1;
                if (update_ie) begin
                    irq_flag <= 1'b1;
                end
                if (alarm_ie && alm_hit) begin
                    alarm_flag <= 1'b1;
                    irq_flag   <= 1'b1;
                end
            end
        end
    end

    assign img_sec   = image[F_SEC];
    assign img_min   = image[F_MIN];
    assign img_hour  = image[F_HOUR];
    assign img_dow   = image[F_DOW];
    assign img_date  = image[F_DATE];
    assign img_month = image[F_MON];
    assign img_year  = image[F_YEAR];

endmodule

module bcd_calendar_checker
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic [2:0] div_sel,
    input logic       set_mode,
    input logic       wr_en,
    input logic [7:0] img_sec,
    input logic [7:0] img_hour,
    input logic       uip,
    input logic       alarm_flag,
    input logic       update_flag,
    input logic       irq_flag,
    input cal_state_e state
);

    assert_div_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && sec_tick && div_sel != 3'b010) |=> !uip);

    assert_uip_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uip |-> (state != ST_IDLE));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !wr_en) |=> ($stable(img_sec) && $stable(img_hour)));

    assert_alarm_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> irq_flag);

    assert_update_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !$past(set_mode)) |-> update_flag);

endmodule

bind bcd_calendar bcd_calendar_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .div_sel     (div_sel),
    .set_mode    (set_mode),
    .wr_en       (wr_en),
    .img_sec     (img_sec),
    .img_hour    (img_hour),
    .uip         (uip),
    .alarm_flag  (alarm_flag),
    .update_flag (update_flag),
    .irq_flag    (irq_flag),
    .state       (state)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4;

    logic       clk, rst_n, sec_tick, set_mode, bin_mode, hr24_mode;
    logic       alarm_ie, update_ie, wr_en, flag_clr;
    logic [2:0] div_sel, wr_sel;
    logic [7:0] alm_sec, alm_min, alm_hour, wr_data;
    logic [7:0] img_sec, img_min, img_hour, img_dow, img_date, img_month, img_year;
    logic       uip, alarm_flag, update_flag, irq_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bcd_calendar #(.UIP_CYCLES(WIN), .CENTURY_BASE(2000)) u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .div_sel(div_sel),
        .set_mode(set_mode), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
        .alarm_ie(alarm_ie), .update_ie(update_ie), .alm_sec(alm_sec),
        .alm_min(alm_min), .alm_hour(alm_hour), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .img_sec(img_sec), .img_min(img_min),
        .img_hour(img_hour), .img_dow(img_dow), .img_date(img_date),
        .img_month(img_month), .img_year(img_year), .uip(uip),
        .alarm_flag(alarm_flag), .update_flag(update_flag), .irq_flag(irq_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int mt[7];
    int mi[7];
    int m_left;
    bit m_uip, m_alm, m_upd, m_irq, m_set_q, m_bin_q, m_h24_q;

    function automatic int enc(int v, bit bin);
        return bin ? v : ((v / 10) * 16 + (v % 10));
    endfunction
    function automatic int dec(int b, bit bin);
        return bin ? (b & 127) : ((((b >> 4) & 15) * 10 + (b & 15)) & 127);
    endfunction
    function automatic int henc(int h, bit bin, bit h24);
        if (h24) return enc(h, bin);
        return ((h >= 12) ? 128 : 0) + enc(h % 12, bin);
    endfunction
    function automatic int hdec(int b, bit bin, bit h24);
        int h = dec(b & 127, bin);
        if (!h24 && b[7]) h = h + 12;
        return h & 127;
    endfunction
    function automatic int month_len(int m, int y);
        int full = 2000 + y;
        bit lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction
    function automatic bit amatch(int a, int v, bit hr, bit bin, bit h24);
        if ((a & 192) == 192) return 1'b1;
        return (hr ? hdec(a, bin, h24) : dec(a, bin)) == v;
    endfunction

    task automatic model_advance();
        mt[0]++;
        if (mt[0] >= 60) begin
            mt[0] = 0; mt[1]++;
            if (mt[1] >= 60) begin
                mt[1] = 0; mt[2]++;
                if (mt[2] >= 24) begin
                    mt[2] = 0;
                    mt[3] = (mt[3] >= 7) ? 1 : mt[3] + 1;
                    if (mt[4] >= month_len(mt[5], mt[6])) begin
                        mt[4] = 1;
                        if (mt[5] >= 12) begin
                            mt[5] = 1;
                            mt[6] = (mt[6] >= 99) ? 0 : mt[6] + 1;
                        end else mt[5]++;
                    end else mt[4]++;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mt = '{0, 0, 0, 1, 1, 1, 0};
            mi = '{0, 0, 0, 1, 1, 1, 0};
            m_left = 0;
            {m_uip, m_alm, m_upd, m_irq, m_set_q, m_bin_q, m_h24_q} = '0;
        end else begin
            int f[7];
            int b[7];
            bit refr, go, rel, mchg, hit;
            refr = (m_left == 1);
            go   = (m_left == 0) && sec_tick && (div_sel == 3'b010);
            for (int i = 0; i < 7; i++)
                f[i] = (i == 2) ? henc(mt[2], bin_mode, hr24_mode) : enc(mt[i], bin_mode);
            for (int i = 0; i < 7; i++) b[i] = (refr && !set_mode) ? f[i] : mi[i];
            if (wr_en && wr_sel < 7) b[wr_sel] = wr_data;
            rel  = m_set_q && !set_mode;
            mchg = ((bin_mode != m_bin_q) || (hr24_mode != m_h24_q)) && !set_mode;
            hit  = amatch(alm_sec, mt[0], 0, bin_mode, hr24_mode) &&
                   amatch(alm_min, mt[1], 0, bin_mode, hr24_mode) &&
                   amatch(alm_hour, mt[2], 1, bin_mode, hr24_mode);
            if ((wr_en && !set_mode) || rel) begin
                for (int i = 0; i < 7; i++)
                    mt[i] = (i == 2) ? hdec(b[2], bin_mode, hr24_mode) : dec(b[i], bin_mode);
            end else if (go) model_advance();
            if (wr_en || (refr && !set_mode)) mi = b;
            else if (mchg) mi = f;
            if (refr || set_mode) m_uip = 0;
            else if (go) m_uip = 1;
            if (flag_clr) {m_alm, m_upd, m_irq} = '0;
            if (refr) begin
                m_upd = 1;
                if (update_ie) m_irq = 1;
                if (alarm_ie && hit) begin m_alm = 1; m_irq = 1; end
            end
            if (go) m_left = WIN + 1;
            else if (m_left > 0) m_left--;
            m_set_q = set_mode; m_bin_q = bin_mode; m_h24_q = hr24_mode;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model sec",   img_sec,   mi[0]);
            chk("R2 model min",   img_min,   mi[1]);
            chk("R5 model hour",  img_hour,  mi[2]);
            chk("R2 model dow",   img_dow,   mi[3]);
            chk("R3 model date",  img_date,  mi[4]);
            chk("R3 model month", img_month, mi[5]);
            chk("R4 model year",  img_year,  mi[6]);
            chk("R6 model uip",   uip,         m_uip);
            chk("R8 model alarm", alarm_flag,  m_alm);
            chk("R9 model upd",   update_flag, m_upd);
            chk("R9 model irq",   irq_flag,    m_irq);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(int sel, int val);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask
    task automatic tick_full();
        tick();
        step(WIN + 2);
    endtask
    task automatic clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask
    task automatic set_time(int h, int m, int s, int d, int mo, int y);
        wr(2, h); wr(1, m); wr(0, s); wr(4, d); wr(5, mo); wr(6, y);
    endtask

    initial begin
        rst_n = 0; sec_tick = 0; div_sel = 3'b010; set_mode = 0; bin_mode = 0;
        hr24_mode = 1; alarm_ie = 0; update_ie = 0; alm_sec = 8'hC0; alm_min = 8'hC0;
        alm_hour = 8'hC0; wr_en = 0; wr_sel = 0; wr_data = 0; flag_clr = 0;
        step(3);
        rst_n = 1;
        // reset state
        chk("R2 reset sec", img_sec, 8'h00);
        chk("R2 reset dow", img_dow, 8'h01);
        chk("R6 reset uip", uip, 0);
        chk("R9 reset flags", {alarm_flag, update_flag, irq_flag}, 0);
        step(2);

        // R2 full rollover in BCD
        set_time(8'h23, 8'h59, 8'h58, 8'h31, 8'h12, 8'h99);
        wr(3, 8'h07);
        tick();
        chk("R6 uip after tick", uip, 1);
        step(WIN + 2);
        chk("R6 uip cleared", uip, 0);
        chk("R2 sec 59", img_sec, 8'h59);
        chk("R9 update flag", update_flag, 1);
        chk("R9 no irq without enable", irq_flag, 0);
        tick_full();
        chk("R2 sec wrap", img_sec, 8'h00);
        chk("R2 hour wrap", img_hour, 8'h00);
        chk("R2 dow wrap", img_dow, 8'h01);
        chk("R2 month wrap", img_month, 8'h01);
        chk("R2 year wrap", img_year, 8'h00);

        // R3 month lengths and leap years
        set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23);
        tick_full();
        chk("R3 non-leap feb date", img_date, 8'h01);
        chk("R3 non-leap feb month", img_month, 8'h03);
        set_time(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h23);
        tick_full();
        chk("R3 april end", img_month, 8'h05);
        set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00);
        tick_full();
        chk("R3 year 2000 leap", img_date, 8'h29);
        set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24);
        tick_full();
        chk("R3 year 2024 leap", img_date, 8'h29);

        // R4 / R10 binary mode rewrite
        bin_mode = 1;
        step(1);
        chk("R10 rewrite date binary", img_date, 8'h1D);
        chk("R4 year binary", img_year, 8'h18);
        wr(0, 8'h3B);
        tick_full();
        chk("R4 binary min carry", img_min, 8'h01);
        chk("R4 binary sec", img_sec, 8'h00);

        // R5 12-hour format
        bin_mode = 0; hr24_mode = 0;
        step(1);
        chk("R10 rewrite 12h", img_hour, 8'h00);
        wr(2, 8'h81);
        hr24_mode = 1;
        step(1);
        chk("R5 PM decode", img_hour, 8'h13);
        hr24_mode = 0;
        step(1);
        chk("R5 PM encode", img_hour, 8'h81);
        wr(2, 8'h80);
        hr24_mode = 1;
        step(1);
        chk("R5 noon", img_hour, 8'h12);

        // R1 divider gate
        clr();
        div_sel = 3'b011;
        tick();
        chk("R1 no uip", uip, 0);
        step(WIN + 2);
        chk("R1 sec held", img_sec, 8'h00);
        chk("R1 no update flag", update_flag, 0);
        div_sel = 3'b010;

        // R7 freeze and release
        set_mode = 1;
        tick();
        chk("R6 uip held low in freeze", uip, 0);
        step(WIN + 2);
        chk("R7 image frozen", img_sec, 8'h00);
        chk("R9 update flag in freeze", update_flag, 1);
        wr(0, 8'h30);
        chk("R7 write visible in freeze", img_sec, 8'h30);
        set_mode = 0;
        step(1);
        tick_full();
        chk("R7 release loads counter", img_sec, 8'h31);

        // R8 alarm
        clr();
        alarm_ie = 1; alm_sec = 8'h32;
        tick_full();
        chk("R8 wildcard alarm", alarm_flag, 1);
        chk("R8 alarm irq", irq_flag, 1);
        clr();
        chk("R9 clear flags", {alarm_flag, update_flag, irq_flag}, 0);
        alm_sec = 8'h10;
        tick_full();
        chk("R8 no match", alarm_flag, 0);
        alm_sec = 8'h34; alm_min = 8'h01; alm_hour = 8'h12;
        tick_full();
        chk("R8 exact match", alarm_flag, 1);
        alarm_ie = 0;

        // R9 update interrupt
        clr();
        update_ie = 1;
        tick_full();
        chk("R9 update irq", irq_flag, 1);
        update_ie = 0;
        clr();

        // R11 write on the refresh edge
        tick();
        step(WIN);
        wr(1, 8'h45);
        chk("R11 written min kept", img_min, 8'h45);
        chk("R11 sec refreshed", img_sec, 8'h36);
        tick_full();
        chk("R11 counter took min", img_min, 8'h45);
        chk("R11 counter sec", img_sec, 8'h37);

        step(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R6 got=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule